// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block serves a load-store integer core as its multiply and divide engine. A one-cycle start pulse launches one of four operations on two 32-bit operands: signed or unsigned multiply, or signed or unsigned divide. The result does not go to a general register. It lands in two dedicated result registers, called HI and LO here, and the core fetches it later with separate move commands. The engine runs one iteration per clock. Multiply uses shift-and-add and divide uses restoring division, each on operand magnitudes. A final cycle applies the sign correction.

The core can also load HI or LO directly from an operand. While an operation is in flight, a read request on HI or LO raises a stall output, so the core holds its pipeline until the result exists. The unit never signals arithmetic overflow. Division by zero completes normally with defined values. A start that arrives while the unit is busy is dropped and flagged.

Top module: `muldiv_unit`

## Requirements
- R1: With op = 2'b01 (unsigned multiply), the 64-bit unsigned product of opa and opb is placed in HI (upper 32 bits) and LO (lower 32 bits).
- R2: With op = 2'b00 (signed multiply), opa and opb are taken as two's complement and the 64-bit signed product is placed in HI (upper) and LO (lower).
- R3: With op = 2'b11 (unsigned divide) and opb nonzero, LO receives opa / opb and HI receives opa mod opb.
- R4: With op = 2'b10 (signed divide) and opb nonzero, the quotient in LO is truncated toward zero and the remainder in HI carries the sign of opa.
- R5: When opb is zero in either divide, LO becomes all ones and HI becomes opa unchanged, with no trap.
- R6: A start accepted while idle makes busy high for exactly 33 cycles, beginning the cycle after start; done is high for a single cycle, which is the first cycle in which busy is low again.
- R7: rd_data shows HI when rd_hi is high and LO otherwise, in the same cycle as the request.
- R8: stall is high exactly when rd_hi or rd_lo is requested while busy is high.
- R9: While idle, ld_hi or ld_lo copies opa into HI or LO at the next clock edge. These loads are dropped while busy. When start is high in the same cycle as a load, start takes precedence and the load is dropped.
- R10: A start while busy is ignored, so the running operation and its result are unaffected. start_err is high in the cycle after the ignored start.
- R11: After reset, HI and LO read zero and busy, done and start_err are low.
- R12: A signed divide of 0x80000000 by 0xFFFFFFFF completes with LO = 0x80000000 and HI = 0, with no overflow indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse for an operation |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand or dividend; also the data source for HI/LO loads |
| opb | input | 32 | Multiplier or divisor |
| rd_hi | input | 1 | Read request for HI |
| rd_lo | input | 1 | Read request for LO |
| ld_hi | input | 1 | Load HI from opa |
| ld_lo | input | 1 | Load LO from opa |
| rd_data | output | 32 | Selected result register |
| stall | output | 1 | Read requested while the engine is busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| start_err | output | 1 | A start was ignored because the unit was busy |

## Verification
The multiply tests combine every sign pairing: both operands negative, mixed signs, the most negative value squared, and all-ones unsigned operands. These show whether the sign fixup and the carry out of the shift-add reach HI. The divide tests place a negative operand on each side in turn, so that a wrong quotient rounding and a remainder taking the divisor's sign fail differently. Zero divisors are applied both signed and unsigned, and the most-negative-by-minus-one case is included. The tests of busy-time behaviour issue a late start, a load and a read in the middle of a run. Each of these should leave the result untouched while the stall and error flags respond.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

    // op[1] selects divide, op[0] selects unsigned
    localparam int OP_DIV_BIT = 1;
    localparam int OP_UNS_BIT = 0;

endpackage

// File: rtl/md_mul_step.sv
module md_mul_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] mcand_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, hi_i} + (lo_i[0] ? {1'b0, mcand_i} : '0);
        hi_o = sum[W:1];
        lo_o = {sum[0], lo_i[W-1:1]};
    end
endmodule

// File: rtl/md_div_step.sv
module md_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    logic [W:0] shifted;
    logic       fits;

    always_comb begin
        shifted = {hi_i, lo_i[W-1]};
        fits    = shifted >= {1'b0, dvs_i};
        hi_o    = fits ? W'(shifted - {1'b0, dvs_i}) : shifted[W-1:0];
        lo_o    = {lo_i[W-2:0], fits};
    end
endmodule

// File: rtl/md_sign_fix.sv
module md_sign_fix #(
    parameter int W = 32
) (
    input  logic         is_div_i,
    input  logic         neg_res_i,
    input  logic         neg_rem_i,
    input  logic         zero_dvs_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    output logic [W-1:0] hi_o,
    output logic [W-1:0] lo_o
);
    localparam int W2 = 2 * W;

    logic [W2-1:0] prod;

    always_comb begin
        prod = {hi_i, lo_i};
        if (!is_div_i) begin
            if (neg_res_i) prod = -prod;
            hi_o = prod[W2-1:W];
            lo_o = prod[W-1:0];
        end else begin
            hi_o = neg_rem_i ? -hi_i : hi_i;
            if (zero_dvs_i)     lo_o = '1;
            else if (neg_res_i) lo_o = -lo_i;
            else                lo_o = lo_i;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         rd_hi,
    input  logic         rd_lo,
    input  logic         ld_hi,
    input  logic         ld_lo,
    output logic [W-1:0] rd_data,
    output logic         stall,
    output logic         busy,
    output logic         done,
    output logic         start_err
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_ITER = CW'(W - 1);

    typedef struct packed {
        md_state_e     st;
        logic [CW-1:0] cnt;
        logic          is_div;
        logic          neg_res;
        logic          neg_rem;
        logic          zero_dvs;
        logic [W-1:0]  dvs;
        logic [W-1:0]  hi;
        logic [W-1:0]  lo;
        logic          done;
        logic          err;
    } md_regs_t;

    md_regs_t q, d;

    logic         sgn_op, a_neg, b_neg;
    logic [W-1:0] a_mag, b_mag;
    logic [W-1:0] mul_hi, mul_lo, div_hi, div_lo, fix_hi, fix_lo;

    md_mul_step #(.W(W)) u_mul (
        .hi_i(q.hi), .lo_i(q.lo), .mcand_i(q.dvs),
        .hi_o(mul_hi), .lo_o(mul_lo)
    );

    md_div_step #(.W(W)) u_div (
        .hi_i(q.hi), .lo_i(q.lo), .dvs_i(q.dvs),
        .hi_o(div_hi), .lo_o(div_lo)
    );

    md_sign_fix #(.W(W)) u_fix (
        .is_div_i(q.is_div), .neg_res_i(q.neg_res), .neg_rem_i(q.neg_rem),
        .zero_dvs_i(q.zero_dvs), .hi_i(q.hi), .lo_i(q.lo),
        .hi_o(fix_hi), .lo_o(fix_lo)
    );

    always_comb begin
        sgn_op = ~op[OP_UNS_BIT];
        a_neg  = sgn_op & opa[W-1];
        b_neg  = sgn_op & opb[W-1];
        a_mag  = a_neg ? -opa : opa;
        b_mag  = b_neg ? -opb : opb;

        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st       = ST_RUN;
                    d.cnt      = '0;
                    d.is_div   = op[OP_DIV_BIT];
                    d.neg_res  = a_neg ^ b_neg;
                    d.neg_rem  = a_neg;
                    d.zero_dvs = (opb == '0);
                    d.hi       = '0;
                    d.lo       = op[OP_DIV_BIT] ? a_mag : b_mag;
                    d.dvs      = op[OP_DIV_BIT] ? b_mag : a_mag;
                end else begin
                    if (ld_hi) d.hi = opa;
                    if (ld_lo) d.lo = opa;
                end
            end
            ST_RUN: begin
                d.hi  = q.is_div ? div_hi : mul_hi;
                d.lo  = q.is_div ? div_lo : mul_lo;
                d.cnt = q.cnt + 1'b1;
                if (q.cnt == LAST_ITER) d.st = ST_FIX;
                d.err = start;
            end
            ST_FIX: begin
                d.hi   = fix_hi;
                d.lo   = fix_lo;
                d.st   = ST_IDLE;
                d.done = 1'b1;
                d.err  = start;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign start_err = q.err;
    assign rd_data   = rd_hi ? q.hi : q.lo;
    assign stall     = (rd_hi | rd_lo) & busy;

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int W = 32
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic stall,
    input logic start_err
);
    logic [7:0] busy_len;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    // R6
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == 8'(W + 1)));

    // R8
    stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> busy);

    // R10
    busy_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> start_err);

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |-> $past(start && busy));

endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .done(done), .stall(stall), .start_err(start_err)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
    localparam int CLK_P = 10;
    localparam int NV    = 12;

    // stimulus: {op, opa, opb}
    localparam logic [65:0] VEC [NV] = '{
        {2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {2'b01, 32'h12345678, 32'h9ABCDEF0},
        {2'b00, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {2'b00, 32'hFFFFFFFD, 32'h00000007},
        {2'b00, 32'h80000000, 32'h80000000},
        {2'b11, 32'h00000064, 32'h00000007},
        {2'b11, 32'hFFFFFFFF, 32'h00000003},
        {2'b11, 32'h00000005, 32'h00000000},
        {2'b10, 32'hFFFFFFF9, 32'h00000002},
        {2'b10, 32'h00000007, 32'hFFFFFFFE},
        {2'b10, 32'h80000000, 32'hFFFFFFFF},
        {2'b10, 32'hFFFFFFF7, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] opa = '0, opb = '0;
    logic        rd_hi = 1'b0, rd_lo = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0;
    logic [31:0] rd_data;
    logic        stall, busy, done, start_err;

    int total = 0;
    int bad   = 0;

    muldiv_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
        .rd_hi(rd_hi), .rd_lo(rd_lo), .ld_hi(ld_hi), .ld_lo(ld_lo),
        .rd_data(rd_data), .stall(stall), .busy(busy), .done(done),
        .start_err(start_err)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void ref_calc(input logic [1:0] o, input logic [31:0] a,
                                     input logic [31:0] b,
                                     output logic [31:0] hi, output logic [31:0] lo);
        logic [63:0] p;
        logic [31:0] ma, mb, qq, rr;
        p = '0;
        case (o)
            2'b01: p = {32'b0, a} * {32'b0, b};
            2'b00: p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
            default: p = '0;
        endcase
        if (!o[1]) begin
            hi = p[63:32];
            lo = p[31:0];
        end else if (b == 0) begin
            hi = a;
            lo = '1;
        end else if (o[0]) begin
            hi = a % b;
            lo = a / b;
        end else begin
            ma = a[31] ? -a : a;
            mb = b[31] ? -b : b;
            qq = ma / mb;
            rr = ma % mb;
            lo = (a[31] ^ b[31]) ? -qq : qq;
            hi = a[31] ? -rr : rr;
        end
    endfunction

    function automatic string tag_of(input logic [1:0] o, input logic [31:0] a,
                                     input logic [31:0] b);
        if (o[1] && b == 0) return "R5";
        if (o == 2'b10 && a == 32'h80000000 && b == 32'hFFFFFFFF) return "R12";
        case (o)
            2'b01:   return "R1";
            2'b00:   return "R2";
            2'b11:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // called at a negedge; returns at the negedge where done is seen
    task automatic launch(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                          output int cyc);
        start = 1'b1; op = o; opa = a; opb = b;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 100) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic read_both(output logic [31:0] hi, output logic [31:0] lo);
        rd_hi = 1'b1; #1; hi = rd_data; rd_hi = 1'b0;
        rd_lo = 1'b1; #1; lo = rd_data; rd_lo = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] h, l, eh, el;
        int cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state
        read_both(h, l);
        check("R11 hi", h, 32'h0);
        check("R11 lo", l, 32'h0);
        check("R11 busy", {31'b0, busy}, 32'h0);
        check("R11 done", {31'b0, done}, 32'h0);
        check("R11 start_err", {31'b0, start_err}, 32'h0);

        // R9 load while idle, R7 read selection
        ld_hi = 1'b1; opa = 32'hA5A5_0001;
        @(negedge clk);
        ld_hi = 1'b0; ld_lo = 1'b1; opa = 32'h5A5A_0002;
        @(negedge clk);
        ld_lo = 1'b0;
        read_both(h, l);
        check("R9 ld_hi", h, 32'hA5A5_0001);
        check("R9 ld_lo", l, 32'h5A5A_0002);
        rd_hi = 1'b1; rd_lo = 1'b1; #1;
        check("R7 hi priority", rd_data, 32'hA5A5_0001);
        check("R8 no stall idle", {31'b0, stall}, 32'h0);
        rd_hi = 1'b0; rd_lo = 1'b0;

        // vector table: R1..R5, R12, and R6 timing
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  vo;
            logic [31:0] va, vb;
            string       tg;
            vo = VEC[i][65:64];
            va = VEC[i][63:32];
            vb = VEC[i][31:0];
            tg = tag_of(vo, va, vb);
            ref_calc(vo, va, vb, eh, el);
            launch(vo, va, vb, cyc);
            check("R6 latency", cyc, 34);
            read_both(h, l);
            check({tg, " hi"}, h, eh);
            check({tg, " lo"}, l, el);
            @(negedge clk);
            check("R6 done single", {31'b0, done}, 32'h0);
        end

        // R8 stall during run, R10 start while busy, R9 load while busy dropped
        start = 1'b1; op = 2'b01; opa = 32'd3; opb = 32'd5;
        @(negedge clk);
        start = 1'b0;
        rd_lo = 1'b1; #1;
        check("R8 stall busy", {31'b0, stall}, 32'h1);
        rd_lo = 1'b0; #1;
        check("R8 no request", {31'b0, stall}, 32'h0);
        cyc = 1;
        repeat (4) begin @(negedge clk); cyc++; end
        start = 1'b1; op = 2'b11; opa = 32'hDEAD; opb = 32'd0;
        ld_hi = 1'b1; ld_lo = 1'b1;
        @(negedge clk); cyc++;
        start = 1'b0; ld_hi = 1'b0; ld_lo = 1'b0;
        check("R10 start_err", {31'b0, start_err}, 32'h1);
        @(negedge clk); cyc++;
        check("R10 err pulse", {31'b0, start_err}, 32'h0);
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        check("R10 latency", cyc, 34);
        rd_hi = 1'b1; #1;
        check("R8 stall after done", {31'b0, stall}, 32'h0);
        rd_hi = 1'b0;
        read_both(h, l);
        check("R10 hi kept", h, 32'd0);
        check("R10 lo kept", l, 32'd15);

        // R9 start wins over simultaneous load
        ld_lo = 1'b1; ld_hi = 1'b1;
        launch(2'b11, 32'd100, 32'd9, cyc);
        ld_lo = 1'b0; ld_hi = 1'b0;
        read_both(h, l);
        check("R9 start wins hi", h, 32'd1);
        check("R9 start wins lo", l, 32'd11);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule